// File: doc/BRIEF.md
# Short-Fault Gate Probe Controller

This block is the last stage before the field-switch gate driver. In normal operation the final gate-enable bit follows the PWM command. A shorted-source comparator can raise a fault flag. While that flag is up, the block stops continuous drive. It lets the PWM through only during short probe windows that repeat at a fixed rate, so that the external switch can be tested without sustained current into the short.

At the end of each probe window the block reads the fault flag once. If the short is still there, it starts another rest period. If the flag has cleared, it returns to normal pass-through. A separate no-load-dump line works as an overriding kill: when it is low, the gate is never enabled.

The timing comes from a prescaler and two tick counts: the probe length and the full period. With the defaults, the probe window is 4 cycles in every 256 (a duty of 1/64, about 1.56%). On silicon, these parameters are chosen so that the probe window is about 158 µs and the repeat rate is about 98.6 Hz.

Top module: `gate_poll_ctrl`

## Requirements
- R1: With the fault state idle and `ld_clear` high, `gate_en` equals `pwm_cmd` in the same cycle.
- R2: A high `short_flt` at a clock edge in the idle state starts a rest phase. From the next cycle on, `gate_en` is 0 for exactly `(PERIOD_TICKS-PULSE_TICKS)*PRESCALE` cycles.
- R3: Each rest phase is followed by a probe window of `PULSE_TICKS*PRESCALE` cycles, during which `gate_en` equals `pwm_cmd & ld_clear`.
- R4: While the fault stays high, probe windows repeat every `PERIOD_TICKS*PRESCALE` cycles. With the defaults this gives exactly 4 enabled cycles in every 256 when `pwm_cmd` is held high.
- R5: During a rest phase, and at every probe-window edge except the last, the value of `short_flt` has no effect on `gate_en`.
- R6: If `short_flt` is low at the final edge of a probe window, `gate_en` follows `pwm_cmd` again from the next cycle. If it is high at that edge, a new rest phase begins.
- R7: When `ld_clear` is 0, `gate_en` is 0 in that same cycle, whatever the other inputs and the phase are.
- R8: Each entry into polling from the idle state restarts the rest phase at its full length. Counts left over from an earlier episode are not reused.
- R9: While `rst_n` is low, the block is held idle and `short_flt` is ignored, so `gate_en` equals `pwm_cmd & ld_clear`. Reset release is synchronised over `SYNC_STAGES` clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_cmd | input | 1 | PWM gate command from the regulator loop |
| short_flt | input | 1 | Shorted-source fault flag from the comparator |
| ld_clear | input | 1 | High when no load-dump overvoltage is present |
| gate_en | output | 1 | Final gate-driver enable |

## Verification
The bench probes the exact edge of each phase. An off-by-one in the rest or probe counter would shift the enabled cycles and change the count of 4 per 256. A design that samples the fault flag continuously would be caught by dropping the flag in the middle of a rest phase and raising it again before the probe ends: such a design would leave polling early and drive continuously. Clearing the flag during a probe window checks that pass-through resumes on the very next cycle and not one period later. Re-entering a fault after a partial episode would expose counters that are not cleared on entry. Load-dump pulses are mixed into every phase, and a design that ignored them in one phase would show an enabled gate there.

// File: rtl/gpoll_pkg.sv
package gpoll_pkg;

  // Phase of the short-fault handling
  typedef enum logic [1:0] {
    GP_DRIVE = 2'd0,  // no fault: PWM passes through
    GP_REST  = 2'd1,  // fault: gate held off
    GP_PROBE = 2'd2   // fault: short test window
  } gp_state_e;

  function automatic int unsigned gp_cnt_width(input int unsigned max_count);
    return (max_count > 1) ? $clog2(max_count) : 1;
  endfunction

endpackage

// File: rtl/gp_rst_sync.sv
module gp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gp_tick_gen.sv
module gp_tick_gen #(
  parameter int unsigned PRESCALE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned PW = gpoll_pkg::gp_cnt_width(PRESCALE);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic          pre_en;

  generate
    if (PRESCALE == 1) begin : g_direct
      assign tick = run;
      always_comb begin
        pre_d  = '0;
        pre_en = 1'b0;
      end
    end else begin : g_divided
      assign tick = run && (pre_q == PRE_LAST);
      always_comb begin
        pre_en = run || (pre_q != '0);
        if (!run || tick) begin
          pre_d = '0;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

  assert_pre_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PRE_LAST);

  assert_pre_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> pre_q == '0);

endmodule

// File: rtl/gp_poll_fsm.sv
module gp_poll_fsm
  import gpoll_pkg::*;
#(
  parameter int unsigned PULSE_TICKS  = 2,
  parameter int unsigned PERIOD_TICKS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic short_flt,
  input  logic tick,
  output logic run,
  output logic probe_open
);

  localparam int unsigned REST_TICKS = PERIOD_TICKS - PULSE_TICKS;
  localparam int unsigned MAX_TICKS  = (REST_TICKS > PULSE_TICKS) ? REST_TICKS : PULSE_TICKS;
  localparam int unsigned CW         = gp_cnt_width(MAX_TICKS);
  localparam logic [CW-1:0] REST_LAST  = CW'(REST_TICKS - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);

  gp_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv;

  // clock enable: idle waits for the fault, polling phases move on ticks
  always_comb begin
    adv = (st_q == GP_DRIVE) ? short_flt : tick;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      GP_DRIVE: begin
        st_d  = GP_REST;
        cnt_d = '0;
      end
      GP_REST: begin
        if (cnt_q == REST_LAST) begin
          st_d  = GP_PROBE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      GP_PROBE: begin
        if (cnt_q == PULSE_LAST) begin
          st_d  = short_flt ? GP_REST : GP_DRIVE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = GP_DRIVE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GP_DRIVE;
      cnt_q <= '0;
    end else if (adv) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign run        = (st_q != GP_DRIVE);
  assign probe_open = (st_q == GP_DRIVE) || (st_q == GP_PROBE);

  assert_rest_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GP_DRIVE && short_flt) |=> (st_q == GP_REST && cnt_q == '0));

  assert_probe_after_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GP_PROBE && $past(st_q) != GP_PROBE) |-> $past(st_q) == GP_REST);

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GP_REST |-> cnt_q <= REST_LAST) and (st_q == GP_PROBE |-> cnt_q <= PULSE_LAST));

  assert_rest_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GP_REST && !(tick && cnt_q == REST_LAST)) |=> st_q == GP_REST);

  assert_exit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GP_DRIVE && $past(st_q) == GP_PROBE) |-> !$past(short_flt));

  assert_entry_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GP_REST && $past(st_q) == GP_DRIVE) |-> cnt_q == '0);

endmodule

// File: rtl/gate_poll_ctrl.sv
module gate_poll_ctrl #(
  parameter int unsigned PRESCALE     = 2,
  parameter int unsigned PULSE_TICKS  = 2,
  parameter int unsigned PERIOD_TICKS = 128,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  input  logic short_flt,
  input  logic ld_clear,
  output logic gate_en
);

  logic rst_sync_n;
  logic run;
  logic tick;
  logic probe_open;

  gp_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  gp_tick_gen #(
    .PRESCALE(PRESCALE)
  ) u_tick (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (run),
    .tick (tick)
  );

  gp_poll_fsm #(
    .PULSE_TICKS (PULSE_TICKS),
    .PERIOD_TICKS(PERIOD_TICKS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .short_flt (short_flt),
    .tick      (tick),
    .run       (run),
    .probe_open(probe_open)
  );

  // final enable: command AND probe stage AND load-dump kill
  assign gate_en = pwm_cmd & probe_open & ld_clear;

  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_sync_n |=> probe_open);

  assert_ld_kill_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ld_clear |-> !gate_en);

endmodule

// File: tb/tb_gate_poll_ctrl.sv
`timescale 1ns/1ps
module tb_gate_poll_ctrl;

  localparam int PRESCALE     = 2;
  localparam int PULSE_TICKS  = 2;
  localparam int PERIOD_TICKS = 128;
  localparam int ON_CYC   = PULSE_TICKS * PRESCALE;
  localparam int REST_CYC = (PERIOD_TICKS - PULSE_TICKS) * PRESCALE;
  localparam int PER_CYC  = PERIOD_TICKS * PRESCALE;
  localparam real HALF    = 10.0;

  logic clk = 1'b0;
  logic rst_n;
  logic pwm_cmd, short_flt, ld_clear;
  logic gate_en;

  int n_checks = 0;
  int n_fail   = 0;
  int m_st     = 0;  // 0 idle, 1 rest, 2 probe
  int m_cnt    = 0;
  bit in_rst   = 1'b1;
  int ones     = 0;

  always #(HALF) clk = ~clk;

  gate_poll_ctrl #(
    .PRESCALE(PRESCALE), .PULSE_TICKS(PULSE_TICKS),
    .PERIOD_TICKS(PERIOD_TICKS), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd),
    .short_flt(short_flt), .ld_clear(ld_clear), .gate_en(gate_en)
  );

  function automatic logic exp_gate(input logic p, input logic n, input int st);
    return p & n & (st != 1);
  endfunction

  function automatic string auto_tag(input logic n, input int st);
    if (!n) return "R7";
    if (st == 1) return "R2";
    if (st == 2) return "R3";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gate_en=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(input logic f);
    case (m_st)
      0: if (f) begin m_st = 1; m_cnt = 0; end
      1: begin
        m_cnt++;
        if (m_cnt == REST_CYC) begin m_st = 2; m_cnt = 0; end
      end
      default: begin
        m_cnt++;
        if (m_cnt == ON_CYC) begin m_st = f ? 1 : 0; m_cnt = 0; end
      end
    endcase
  endtask

  task automatic step(input logic p, input logic f, input logic n, input string tag);
    logic e;
    @(negedge clk);
    pwm_cmd = p; short_flt = f; ld_clear = n;
    #2;
    e = in_rst ? (p & n) : exp_gate(p, n, m_st);
    check((tag == "") ? auto_tag(n, m_st) : tag, gate_en, e);
    if (gate_en === 1'b1) ones++;
    @(posedge clk);
    if (!in_rst) model_update(f);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    #(HALF * 2.0 * 190000.0);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic fr;
    void'($urandom(32'h0005_eed1));
    rst_n = 1'b0; pwm_cmd = 1'b0; short_flt = 1'b0; ld_clear = 1'b1;

    // R9: held in reset, fault ignored
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b1, "R9");
    step(1'b0, 1'b1, 1'b1, "R9");
    step(1'b1, 1'b1, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b1, "R9");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, "R9");
    in_rst = 1'b0;

    // R1: pass-through
    for (int i = 0; i < 20; i++) step(i[0], 1'b0, 1'b1, "R1");

    // R4 / R2 / R3: hold fault, count enabled cycles over two periods
    step(1'b1, 1'b1, 1'b1, "R2");
    ones = 0;
    for (int i = 0; i < 2 * PER_CYC; i++) step(1'b1, 1'b1, 1'b1, "R4");
    check("R4", (ones == 2 * ON_CYC) ? 1'b1 : 1'b0, 1'b1);
    if (ones != 2 * ON_CYC) $display("FAIL R4: enabled cycles=%0d expected %0d", ones, 2 * ON_CYC);

    // R5: drop fault in mid-rest, raise again before probe end
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 1'b1, "R5");
    for (int i = 0; i < REST_CYC; i++) step(1'b1, (m_st == 2) ? 1'b1 : i[2], 1'b1, "R5");
    while (m_st != 1) step(1'b1, 1'b1, 1'b1, "R5");

    // R6: clear fault during probe window
    while (m_st != 2) step(1'b1, 1'b1, 1'b1, "R6");
    for (int i = 0; i < ON_CYC + 4; i++) step(1'b1, 1'b0, 1'b1, "R6");

    // R8: short episode, then re-enter: full rest again
    step(1'b1, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b1, "R8");
    while (m_st != 0) step(1'b1, 1'b0, 1'b1, "R8");
    step(1'b1, 1'b1, 1'b1, "R8");
    for (int i = 0; i < PER_CYC; i++) step(1'b1, 1'b0, 1'b1, "R8");

    // R7: load dump across phases
    step(1'b1, 1'b1, 1'b0, "R7");
    for (int i = 0; i < PER_CYC + 8; i++) step(1'b1, 1'b1, i[1], "");

    // random mix
    fr = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 200 == 0) fr = ~fr;
      step(($urandom % 4) != 0, fr, ($urandom % 32) != 0, "");
    end

    summary();
    $finish;
  end

endmodule